// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block moves a single 16-bit data word over a three-wire synchronous serial link: it generates the serial clock, drives one data line and samples another. The host writes the data word while the port is idle, chooses a mode, a clock idle level, a sampling edge, a bit order, a clock divisor and a 16-bit transfer count, and then pulses a start request. When the programmed number of serial clocks has been produced, the port raises a one-cycle done flag and returns to idle.

The data word is never re-aligned. The port shifts toward the output end, and received bits enter at the opposite end. A transfer shorter than 16 bits therefore sends from one end of the word and fills the other. A transfer longer than 16 bits leaves only the newest 16 received bits in the word. Clock-only mode generates serial clocks and moves no data, for any count up to 65535.

Top module: `ssp_port`

## Requirements
- R1: After reset, busy, done and the data line out are 0, the data word reads 0, and the serial clock sits at the level selected by cfgIdleHigh.
- R2: loadData while idle writes loadValue into the data word, which is visible the next cycle. While busy, loadData is ignored.
- R3: A transfer of count N≥1 with divisor D produces exactly N serial clock pulses. Each half period lasts D+1 system clocks. done rises exactly 2·N·(D+1) cycles after the start edge. The clock rests at the idle level (cfgIdleHigh=1 means high) whenever no transfer is running.
- R4: With cfgLsbFirst=0 and mode 3 (bidirectional), bit 15 is sent first. Each shift moves the word toward bit 15, and received bits enter at bit 0.
- R5: With cfgLsbFirst=1, bit 0 is sent first. Each shift moves the word toward bit 0, and received bits enter at bit 15.
- R6: A transfer shorter than 16 bits is not justified. After an 8-bit MSB-first exchange, the word is {old low byte, received byte}. After an LSB-first exchange of n bits, the received bits occupy the top n positions.
- R7: cfgMode encodes 0 = clock only, 1 = transmit only (zeros enter the word), 2 = receive only (serOut held at 0), 3 = bidirectional.
- R8: In clock-only mode, the data word is unchanged and serOut stays 0 while N clocks are produced, for N up to 65535.
- R9: With a count above 16, the data word ends holding the last 16 bits received.
- R10: With cfgLateSample=0, serIn is sampled on the edge leaving the idle level and serOut changes on the edge returning to it. With cfgLateSample=1, these roles swap.
- R11: done is high for exactly one cycle, in the same cycle that busy falls.
- R12: startReq while busy is ignored. A request on the final cycle of a transfer neither extends it nor starts a new one.
- R13: A start with a count of 0 raises done on the next cycle and produces no clock edge. busy never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start a transfer (taken when idle) |
| loadData | input | 1 | Write loadValue into the data word (taken when idle) |
| loadValue | input | 16 | Word to load |
| cfgMode | input | 2 | 0 clock only, 1 transmit, 2 receive, 3 both |
| cfgLsbFirst | input | 1 | Bit order select |
| cfgLateSample | input | 1 | Sample on the return-to-idle edge |
| cfgIdleHigh | input | 1 | Serial clock idle level |
| cfgDivisor | input | 16 | Half period minus one, in system clocks |
| cfgCount | input | 16 | Number of serial clocks in the transfer |
| serIn | input | 1 | Serial data in |
| serClk | output | 1 | Serial clock |
| serOut | output | 1 | Serial data out |
| busy | output | 1 | Transfer in progress |
| donePulse | output | 1 | One-cycle end-of-transfer flag |
| dataReg | output | 16 | Current data word |

## Verification
The last shift of a transfer and a new host request can fall on the same system clock edge. On that edge, busy is still high, so the load and the start must both be ignored. The bench provokes this by asserting loadData, with an all-ones value, together with startReq during exactly the cycle that ends in the final shift. It judges the outcome by three things: the data word must hold the model's expected result rather than all ones, done must appear on schedule, and busy must stay low afterwards. The same kind of collision is covered at zero-count starts, where done must follow a start with no clock edge in between.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    MODE_CLOCK = 2'd0,
    MODE_TX    = 2'd1,
    MODE_RX    = 2'd2,
    MODE_BOTH  = 2'd3
  } xferMode_e;

  typedef struct packed {
    logic load;      // host write of the data word
    logic sample;    // capture serial input
    logic shift;     // advance the data word by one bit
    logic txEn;      // drive the output line
    logic rxEn;      // feed captured bits into the word
    logic lsbFirst;  // output end is bit 0
  } dpStrobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             loadData,
  input  logic [1:0]       cfgMode,
  input  logic             cfgLsbFirst,
  input  logic             cfgLateSample,
  input  logic             cfgIdleHigh,
  input  logic [DIV_W-1:0] cfgDivisor,
  input  logic [CNT_W-1:0] cfgCount,
  output dpStrobe_t        strb,
  output logic             busy,
  output logic             donePulse,
  output logic             serClk
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             busyQ, phaseB, doneQ;
  logic [DIV_W-1:0] divCnt, divQ;
  logic [CNT_W-1:0] bitCnt;
  xferMode_e        modeQ;
  logic             lsbQ, lateQ, idleQ;
  logic             halfEnd;

  assign halfEnd = busyQ && (divCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      phaseB <= 1'b0;
      doneQ  <= 1'b0;
      divCnt <= '0;
      divQ   <= '0;
      bitCnt <= '0;
      modeQ  <= MODE_CLOCK;
      lsbQ   <= 1'b0;
      lateQ  <= 1'b0;
      idleQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (startReq) begin
          modeQ <= xferMode_e'(cfgMode);
          lsbQ  <= cfgLsbFirst;
          lateQ <= cfgLateSample;
          idleQ <= cfgIdleHigh;
          divQ  <= cfgDivisor;
          if (cfgCount == '0) begin
            doneQ <= 1'b1;
          end else begin
            busyQ  <= 1'b1;
            phaseB <= 1'b0;
            divCnt <= cfgDivisor;
            bitCnt <= cfgCount;
          end
        end
      end else if (divCnt != '0) begin
        divCnt <= divCnt - 1'b1;
      end else if (!phaseB) begin
        phaseB <= 1'b1;
        divCnt <= divQ;
      end else if (bitCnt == CNT_ONE) begin
        busyQ  <= 1'b0;
        phaseB <= 1'b0;
        doneQ  <= 1'b1;
        bitCnt <= '0;
      end else begin
        phaseB <= 1'b0;
        divCnt <= divQ;
        bitCnt <= bitCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strb.load     = loadData && !busyQ;
    strb.sample   = halfEnd && !phaseB;
    strb.shift    = halfEnd && phaseB && (modeQ != MODE_CLOCK);
    strb.txEn     = busyQ && modeQ[0];
    strb.rxEn     = modeQ[1];
    strb.lsbFirst = lsbQ;
  end

  assign busy      = busyQ;
  assign donePulse = doneQ;
  assign serClk    = busyQ ? (idleQ ^ phaseB ^ lateQ) : cfgIdleHigh;

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    (doneQ && !(startReq && cfgCount == '0)) |=> !doneQ);

  assert_busy_fall_done_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> doneQ);

  assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startReq) |=> (bitCnt == $past(bitCnt) || bitCnt == $past(bitCnt) - CNT_ONE
                             || bitCnt == '0));

  assert_zero_count_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && startReq && cfgCount == '0) |=> (doneQ && !busyQ));

  assert_half_len_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ) && phaseB != $past(phaseB)) |-> $past(divCnt) == '0);
endmodule

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] loadValue,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] dataReg
);
  localparam int TOP = DATA_W - 1;

  logic [DATA_W-1:0] shiftQ;
  logic              sampleBit;
  logic              inBit;
  logic              outBit;

  assign inBit  = strb.rxEn ? sampleBit : 1'b0;
  assign outBit = strb.lsbFirst ? shiftQ[0] : shiftQ[TOP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ    <= '0;
      sampleBit <= 1'b0;
    end else begin
      if (strb.sample) sampleBit <= serIn;
      if (strb.load) begin
        shiftQ <= loadValue;
      end else if (strb.shift) begin
        if (strb.lsbFirst) shiftQ <= {inBit, shiftQ[TOP:1]};
        else               shiftQ <= {shiftQ[TOP-1:0], inBit};
      end
    end
  end

  assign serOut  = strb.txEn & outBit;
  assign dataReg = shiftQ;

  assert_clkonly_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.txEn && !strb.rxEn && !strb.load) |=> $stable(shiftQ));
endmodule

// File: rtl/ssp_port.sv
module ssp_port
  import ssp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              loadData,
  input  logic [DATA_W-1:0] loadValue,
  input  logic [1:0]        cfgMode,
  input  logic              cfgLsbFirst,
  input  logic              cfgLateSample,
  input  logic              cfgIdleHigh,
  input  logic [DIV_W-1:0]  cfgDivisor,
  input  logic [CNT_W-1:0]  cfgCount,
  input  logic              serIn,
  output logic              serClk,
  output logic              serOut,
  output logic              busy,
  output logic              donePulse,
  output logic [DATA_W-1:0] dataReg
);
  dpStrobe_t strb;

  ssp_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .loadData(loadData),
    .cfgMode(cfgMode), .cfgLsbFirst(cfgLsbFirst), .cfgLateSample(cfgLateSample),
    .cfgIdleHigh(cfgIdleHigh), .cfgDivisor(cfgDivisor), .cfgCount(cfgCount),
    .strb(strb), .busy(busy), .donePulse(donePulse), .serClk(serClk)
  );

  ssp_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .loadValue(loadValue), .serIn(serIn),
    .serOut(serOut), .dataReg(dataReg)
  );
endmodule

// File: tb/test_ssp_port.sv
module test_ssp_port;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk = 1'b0, rstN = 1'b0;
  logic startReq = 1'b0, loadData = 1'b0;
  logic [15:0] loadValue = '0;
  logic [1:0]  cfgMode = '0;
  logic cfgLsbFirst = 1'b0, cfgLateSample = 1'b0, cfgIdleHigh = 1'b0;
  logic [15:0] cfgDivisor = '0, cfgCount = '0;
  logic serIn = 1'b0;
  logic serClk, serOut, busy, donePulse;
  logic [15:0] dataReg;

  int checks = 0, fails = 0;
  bit finished = 0;

  // scoreboard state
  logic expOutQ[$];
  bit   monOn = 0;
  logic curIdle = 0, curLate = 0, prevClk = 0;
  logic [31:0] curRx = '0;
  int   rxIdx = 0, edgeCount = 0;
  string curTag = "";

  always #(CLK_PERIOD/2) clk = ~clk;

  ssp_port i_ssp_port (
    .clk(clk), .rstN(rstN), .startReq(startReq), .loadData(loadData),
    .loadValue(loadValue), .cfgMode(cfgMode), .cfgLsbFirst(cfgLsbFirst),
    .cfgLateSample(cfgLateSample), .cfgIdleHigh(cfgIdleHigh),
    .cfgDivisor(cfgDivisor), .cfgCount(cfgCount), .serIn(serIn),
    .serClk(serClk), .serOut(serOut), .busy(busy), .donePulse(donePulse),
    .dataReg(dataReg)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // monitor: pops expected output bits at each sampling edge, drives next input bit
  always @(negedge clk) begin
    if (monOn && serClk !== prevClk) begin
      if (serClk !== curIdle) edgeCount++;
      if (serClk === (curLate ? curIdle : ~curIdle)) begin
        if (expOutQ.size() == 0) begin
          chk(curTag, "unexpected sample edge", 1, 0);
        end else begin
          logic e;
          e = expOutQ.pop_front();
          chk(curTag, "serOut bit (R10 edge)", {31'd0, serOut}, {31'd0, e});
        end
        rxIdx++;
        serIn = curRx[rxIdx % 32];
      end
    end
    prevClk = serClk;
  end

  task automatic loadWord(input logic [15:0] w);
    @(negedge clk);
    loadData = 1'b1; loadValue = w;
    @(negedge clk);
    loadData = 1'b0;
  endtask

  // driver: computes expected line bits and final word, runs one transfer
  task automatic xfer(input string tag, input logic [1:0] mode, input logic lsb,
                      input logic late, input logic idleHi, input int div,
                      input int cnt, input logic [15:0] txWord,
                      input logic [31:0] rxBits, input bit poke);
    logic [15:0] m;
    int cyc;
    int expCyc;
    loadWord(txWord);
    m = txWord;
    expOutQ.delete();
    for (int i = 0; i < cnt; i++) begin
      logic ob, ib;
      ob = lsb ? m[0] : m[15];
      expOutQ.push_back(mode[0] ? ob : 1'b0);
      ib = mode[1] ? rxBits[i % 32] : 1'b0;
      if (mode != 2'd0) m = lsb ? {ib, m[15:1]} : {m[14:0], ib};
    end
    expCyc = 2 * cnt * (div + 1);
    @(negedge clk);
    cfgMode = mode; cfgLsbFirst = lsb; cfgLateSample = late; cfgIdleHigh = idleHi;
    cfgDivisor = 16'(div); cfgCount = 16'(cnt);
    curIdle = idleHi; curLate = late; curRx = rxBits; curTag = tag;
    rxIdx = 0; edgeCount = 0; serIn = rxBits[0];
    #1 prevClk = serClk; monOn = 1;
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    cyc = 0;
    if (poke) begin
      repeat (expCyc - 1) @(posedge clk);
      @(negedge clk);
      loadData = 1'b1; loadValue = 16'hFFFF; startReq = 1'b1;
      @(posedge clk);
      @(negedge clk);
      loadData = 1'b0; startReq = 1'b0;
      cyc = expCyc;
    end else begin
      while (donePulse !== 1'b1 && cyc < WATCHDOG) begin
        @(posedge clk);
        @(negedge clk);
        cyc++;
      end
    end
    chk("R11", {tag, " done at end"}, {31'd0, donePulse}, 32'd1);
    chk("R11", {tag, " busy low with done"}, {31'd0, busy}, 32'd0);
    chk("R3", {tag, " cycles to done"}, cyc, expCyc);
    chk("R3", {tag, " clock pulses"}, edgeCount, cnt);
    chk(tag, "final data word", {16'd0, dataReg}, {16'd0, m});
    chk(tag, "all output bits seen", expOutQ.size(), 0);
    @(negedge clk);
    monOn = 0;
    chk("R11", {tag, " done one cycle"}, {31'd0, donePulse}, 32'd0);
    chk("R3", {tag, " clock idle after"}, {31'd0, serClk}, {31'd0, idleHi});
    if (poke) begin
      chk("R12", "start in final cycle ignored", {31'd0, busy}, 32'd0);
      chk("R2", "load in final cycle ignored", {16'd0, dataReg}, {16'd0, m});
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    #(CLK_PERIOD * 3);
    #1;
    // R1 reset state
    chk("R1", "busy", {31'd0, busy}, 0);
    chk("R1", "done", {31'd0, donePulse}, 0);
    chk("R1", "serOut", {31'd0, serOut}, 0);
    chk("R1", "dataReg", {16'd0, dataReg}, 0);
    chk("R1", "serClk idle low", {31'd0, serClk}, 0);
    cfgIdleHigh = 1'b1;
    #1 chk("R1", "serClk idle high", {31'd0, serClk}, 1);
    @(negedge clk) rstN = 1'b1;

    // R2 load while idle
    loadWord(16'hA5C3);
    chk("R2", "load idle", {16'd0, dataReg}, 32'hA5C3);

    xfer("R4", 2'd3, 1'b0, 1'b0, 1'b0, 1, 16, 16'hA5C3, 32'h00003C96, 0);
    xfer("R5", 2'd3, 1'b1, 1'b1, 1'b1, 2, 16, 16'h1E87, 32'h0000B4D2, 0);
    xfer("R10", 2'd3, 1'b0, 1'b1, 1'b0, 0, 16, 16'h7F01, 32'h000055AA, 0);
    xfer("R6", 2'd3, 1'b0, 1'b0, 1'b0, 1, 8, 16'h12AB, 32'h000000C5, 0);
    xfer("R6", 2'd3, 1'b1, 1'b0, 1'b1, 0, 5, 16'hF0F0, 32'h00000013, 0);
    xfer("R7", 2'd1, 1'b0, 1'b0, 1'b0, 1, 10, 16'hC3A5, 32'hFFFFFFFF, 0);
    xfer("R7", 2'd2, 1'b1, 1'b0, 1'b0, 1, 12, 16'hFFFF, 32'h00000A5B, 0);
    xfer("R8", 2'd0, 1'b0, 1'b0, 1'b1, 0, 300, 16'hBEEF, 32'hFFFFFFFF, 0);
    xfer("R9", 2'd3, 1'b0, 1'b0, 0, 0, 20, 16'h0F0F, 32'h000C3A96, 0);
    xfer("R4", 2'd3, 1'b0, 1'b0, 1'b0, 1, 16, 16'h6699, 32'h00001234, 1);

    // R13 zero count
    @(negedge clk);
    cfgCount = 16'd0; cfgMode = 2'd3; cfgIdleHigh = 1'b0;
    #1 prevClk = serClk; curIdle = 1'b0; curTag = "R13"; edgeCount = 0; monOn = 1;
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    chk("R13", "done next cycle", {31'd0, donePulse}, 1);
    chk("R13", "busy never set", {31'd0, busy}, 0);
    @(negedge clk);
    chk("R13", "done cleared", {31'd0, donePulse}, 0);
    chk("R13", "no clock edge", edgeCount, 0);
    monOn = 0;

    summary();
  end
endmodule